// File: doc/BRIEF.md
# Guarded Channel Control Registers

This block is the command-driven register file for a sixteen-channel monitor. Each command arrives as a 5-bit function code and a 4-bit subaddress, qualified by a one-cycle strobe. Writes take their operand from a 16-bit write bus. The block answers every strobed command in the same cycle with 16-bit read data and a Q acknowledge bit. Q is high when the command is accepted and low when it is refused.

The block holds several kinds of state. Each channel has a latched over-threshold flag, which is set by a live comparator level and cleared when it is read. Each channel also has a lock bit, a test-drive bit and a 12-bit threshold. One global lock makes the channel locks active. The block also holds a 5-bit serial port address and a fixed identification word.

The global lock guards the configuration. While it is on, locked channels keep their test bits and thresholds, and the lock register, the port address and the clear command are all frozen. The test bits, the thresholds and the port address are driven out to the surrounding hardware. An OR of all flags is stretched in time to drive a visible indicator.

Top module: `guarded_chan_regs`

## Requirements
- R1: A comparator level that is high at a clock edge sets that channel's trip flag (channel n in bit n). The flag stays set until a read-and-reset or an executed clear.
- R2: Function 0, subaddress 0 returns the live comparator levels on the read bus with Q=1.
- R3: Function 2, subaddress 0 returns the trip flags with Q=1 and clears them at that edge. A flag whose comparator is high in that same cycle stays set.
- R4: The indicator output is high while any trip flag is set, and for STRETCH_CYC more clock cycles after the last flag clears.
- R5: Function 29 turns the global lock off with subaddress 0 and on with subaddress 1, with Q=1. It is off after reset. A channel lock protects its channel only while the global lock is on.
- R6: Function 17, subaddress 12 loads the channel lock register, and function 1, subaddress 12 reads it with Q=1. While the global lock is on, the load is refused with Q=0 and the register is left unchanged.
- R7: Function 17, subaddress 11 loads the port address from write bits 4:0, and function 1, subaddress 11 reads it zero-extended with Q=1. The address is 31 after reset. While the global lock is on, the load is refused with Q=0.
- R8: Function 18, subaddress 14 loads the test bits of unprotected channels only. It answers Q=0 if any channel is protected. Function 2, subaddress 14 reads the test bits with Q=1.
- R9: Function 21, subaddress n loads write bits 11:0 into threshold n, with Q=1. The load is refused with Q=0 when channel n is protected. Function 5, subaddress n reads threshold n zero-extended with Q=1.
- R10: Function 9, subaddress 0 runs only while the global lock is off, and then answers Q=1. It zeroes the lock, test and threshold registers, sets the address to 31, and reloads the trip flags from the live comparators. While the global lock is on, it changes nothing and answers Q=0.
- R11: Function 3, subaddress 0 returns 0x42 in bits 15:8 and the SERIAL_NO parameter in bits 7:0, with Q=1.
- R12: Without a strobe, the read bus and Q are 0. A strobed command not listed here returns 0 with Q=0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_fn | input | 5 | Function code |
| cmd_sub | input | 4 | Subaddress / channel number |
| cmd_stb | input | 1 | Command strobe, one cycle per command |
| wr_data | input | 16 | Write operand |
| cmp_level | input | 16 | Live comparator levels, channel n in bit n |
| rd_data | output | 16 | Read data, valid during the strobe |
| rsp_q | output | 1 | Accept acknowledge, valid during the strobe |
| test_out | output | 16 | Test-drive bits |
| thr_out | output | 192 | Thresholds, channel n at bits 12n+11:12n |
| port_addr | output | 5 | Serial port address |
| trip_led | output | 1 | Stretched OR of all trip flags |

## Verification
Two functions can fall in the same edge: a read-and-reset (or an executed clear) that empties the trip flags, and a comparator that sets a flag. The bench holds comparator levels high across successive read-and-reset commands, and then drops them just before a final one. It judges the result by the next read, which must still show the flags that were live at the reset edge and lose them only once the comparator is low. A second collision is a protected write arriving while the global lock is toggled, checked by reading the channel state back through the normal read commands.

// File: rtl/chanreg_pkg.sv
package chanreg_pkg;

    localparam int NCH     = 16;
    localparam int CH_W    = $clog2(NCH);
    localparam int TH_W    = 12;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 16;
    localparam int FN_W    = 5;
    localparam int ID_HI   = 8'h42;
    localparam logic [ADDR_W-1:0] ADDR_RST = '1;

    localparam logic [FN_W-1:0] FN_RD_A    = 5'd0;
    localparam logic [FN_W-1:0] FN_RD_B    = 5'd1;
    localparam logic [FN_W-1:0] FN_RD_C    = 5'd2;
    localparam logic [FN_W-1:0] FN_RD_ID   = 5'd3;
    localparam logic [FN_W-1:0] FN_RD_THR  = 5'd5;
    localparam logic [FN_W-1:0] FN_CLEAR   = 5'd9;
    localparam logic [FN_W-1:0] FN_WR_A    = 5'd17;
    localparam logic [FN_W-1:0] FN_WR_TEST = 5'd18;
    localparam logic [FN_W-1:0] FN_WR_THR  = 5'd21;
    localparam logic [FN_W-1:0] FN_GLOCK   = 5'd29;

    localparam logic [CH_W-1:0] SA_ADDR = 4'd11;
    localparam logic [CH_W-1:0] SA_LOCK = 4'd12;
    localparam logic [CH_W-1:0] SA_TEST = 4'd14;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_RD_CMP,
        OP_RD_TRIP_RST,
        OP_RD_LOCK,
        OP_WR_LOCK,
        OP_RD_ADDR,
        OP_WR_ADDR,
        OP_RD_TEST,
        OP_WR_TEST,
        OP_RD_THR,
        OP_WR_THR,
        OP_RD_ID,
        OP_CLEAR,
        OP_GLOCK_OFF,
        OP_GLOCK_ON
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [CH_W-1:0]  chan;
        logic [DATA_W-1:0] data;
    } cmd_t;

    function automatic logic [DATA_W-1:0] zext_thr(input logic [TH_W-1:0] v);
        return {{(DATA_W-TH_W){1'b0}}, v};
    endfunction

    function automatic logic [DATA_W-1:0] zext_addr(input logic [ADDR_W-1:0] v);
        return {{(DATA_W-ADDR_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/chanreg_decode.sv
module chanreg_decode
    import chanreg_pkg::*;
(
    input  logic              stb,
    input  logic [FN_W-1:0]   fn,
    input  logic [CH_W-1:0]   sub,
    input  logic [DATA_W-1:0] wdata,
    output cmd_t              cmd
);

    op_e op;

    always_comb begin
        op = OP_NONE;
        if (stb) begin
            unique case (fn)
                FN_RD_A:    if (sub == '0) op = OP_RD_CMP;
                FN_RD_B: begin
                    if (sub == SA_ADDR)      op = OP_RD_ADDR;
                    else if (sub == SA_LOCK) op = OP_RD_LOCK;
                end
                FN_RD_C: begin
                    if (sub == '0)           op = OP_RD_TRIP_RST;
                    else if (sub == SA_TEST) op = OP_RD_TEST;
                end
                FN_RD_ID:   if (sub == '0) op = OP_RD_ID;
                FN_RD_THR:  op = OP_RD_THR;
                FN_CLEAR:   if (sub == '0) op = OP_CLEAR;
                FN_WR_A: begin
                    if (sub == SA_ADDR)      op = OP_WR_ADDR;
                    else if (sub == SA_LOCK) op = OP_WR_LOCK;
                end
                FN_WR_TEST: if (sub == SA_TEST) op = OP_WR_TEST;
                FN_WR_THR:  op = OP_WR_THR;
                FN_GLOCK: begin
                    if (sub == 4'd0)      op = OP_GLOCK_OFF;
                    else if (sub == 4'd1) op = OP_GLOCK_ON;
                end
                default:    op = OP_NONE;
            endcase
        end
    end

    assign cmd = '{op: op, chan: sub, data: wdata};

endmodule

// File: rtl/chanreg_trip_bank.sv
module chanreg_trip_bank
    import chanreg_pkg::*;
#(
    parameter int STRETCH_CYC = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] cmp_level,
    input  logic           rd_reset,
    input  logic           clear_go,
    output logic [NCH-1:0] trip_q,
    output logic           trip_led
);

    localparam int CNT_W = $clog2(STRETCH_CYC + 1);

    logic [CNT_W-1:0] hold_cnt;
    logic             any_trip;

    assign any_trip = |trip_q;

    // A reset of the flags reloads them from the live levels, so a level
    // that is still high keeps its flag set across the reset edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            trip_q <= '0;
        end else if (rd_reset || clear_go) begin
            trip_q <= cmp_level;
        end else begin
            trip_q <= trip_q | cmp_level;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
        end else if (any_trip) begin
            hold_cnt <= CNT_W'(STRETCH_CYC);
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    assign trip_led = any_trip || (hold_cnt != '0);

    AST_TRIP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((trip_q & $past(cmp_level)) == $past(cmp_level))); // R1

    AST_LED_TAIL: assert property (@(posedge clk) disable iff (rst)
        $fell(trip_led) |-> (!any_trip && !$past(any_trip))); // R4

endmodule

// File: rtl/chanreg_lock_ctl.sv
module chanreg_lock_ctl
    import chanreg_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  cmd_t           cmd,
    output logic           glob_on,
    output logic [NCH-1:0] chan_lock,
    output logic [NCH-1:0] eff_lock,
    output logic           clear_go
);

    assign clear_go = (cmd.op == OP_CLEAR) && !glob_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_on <= 1'b0;
        end else if (cmd.op == OP_GLOCK_ON) begin
            glob_on <= 1'b1;
        end else if (cmd.op == OP_GLOCK_OFF) begin
            glob_on <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_go) begin
            chan_lock <= '0;
        end else if (cmd.op == OP_WR_LOCK && !glob_on) begin
            chan_lock <= cmd.data[NCH-1:0];
        end
    end

    assign eff_lock = chan_lock & {NCH{glob_on}};

    AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        glob_on |=> $stable(chan_lock)); // R6

    AST_GLOCK_ON: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_GLOCK_ON) |=> glob_on); // R5

endmodule

// File: rtl/chanreg_cfg_regs.sv
module chanreg_cfg_regs
    import chanreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic              clear_go,
    input  logic              glob_on,
    input  logic [NCH-1:0]    eff_lock,
    output logic [NCH-1:0]    test_q,
    output logic [TH_W-1:0]   thr_q [NCH],
    output logic [ADDR_W-1:0] addr_q
);

    always_ff @(posedge clk) begin
        if (rst || clear_go) begin
            test_q <= '0;
        end else if (cmd.op == OP_WR_TEST) begin
            test_q <= (test_q & eff_lock) | (cmd.data[NCH-1:0] & ~eff_lock);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_go) begin
            addr_q <= ADDR_RST;
        end else if (cmd.op == OP_WR_ADDR && !glob_on) begin
            addr_q <= cmd.data[ADDR_W-1:0];
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_thr
            always_ff @(posedge clk) begin
                if (rst || clear_go) begin
                    thr_q[g] <= '0;
                end else if (cmd.op == OP_WR_THR && cmd.chan == CH_W'(g)
                             && !eff_lock[g]) begin
                    thr_q[g] <= cmd.data[TH_W-1:0];
                end
            end

            AST_THR_LOCKED: assert property (@(posedge clk) disable iff (rst)
                eff_lock[g] |=> $stable(thr_q[g])); // R9

            AST_TEST_LOCKED: assert property (@(posedge clk) disable iff (rst)
                eff_lock[g] |=> $stable(test_q[g])); // R8
        end
    endgenerate

    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        glob_on |=> $stable(addr_q)); // R7

endmodule

// File: rtl/guarded_chan_regs.sv
module guarded_chan_regs
    import chanreg_pkg::*;
#(
    parameter logic [7:0] SERIAL_NO   = 8'h5C,
    parameter int         STRETCH_CYC = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [FN_W-1:0]       cmd_fn,
    input  logic [CH_W-1:0]       cmd_sub,
    input  logic                  cmd_stb,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [NCH-1:0]        cmp_level,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rsp_q,
    output logic [NCH-1:0]        test_out,
    output logic [NCH*TH_W-1:0]   thr_out,
    output logic [ADDR_W-1:0]     port_addr,
    output logic                  trip_led
);

    cmd_t              cmd;
    logic              glob_on;
    logic              clear_go;
    logic [NCH-1:0]    chan_lock;
    logic [NCH-1:0]    eff_lock;
    logic [NCH-1:0]    trip_q;
    logic [TH_W-1:0]   thr_q [NCH];
    logic [ADDR_W-1:0] addr_q;

    chanreg_decode u_decode (
        .stb   (cmd_stb),
        .fn    (cmd_fn),
        .sub   (cmd_sub),
        .wdata (wr_data),
        .cmd   (cmd)
    );

    chanreg_lock_ctl u_lock (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .glob_on   (glob_on),
        .chan_lock (chan_lock),
        .eff_lock  (eff_lock),
        .clear_go  (clear_go)
    );

    chanreg_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .clear_go (clear_go),
        .glob_on  (glob_on),
        .eff_lock (eff_lock),
        .test_q   (test_out),
        .thr_q    (thr_q),
        .addr_q   (addr_q)
    );

    chanreg_trip_bank #(
        .STRETCH_CYC (STRETCH_CYC)
    ) u_trip (
        .clk       (clk),
        .rst       (rst),
        .cmp_level (cmp_level),
        .rd_reset  (cmd.op == OP_RD_TRIP_RST),
        .clear_go  (clear_go),
        .trip_q    (trip_q),
        .trip_led  (trip_led)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_thr_out
            assign thr_out[g*TH_W +: TH_W] = thr_q[g];
        end
    endgenerate

    assign port_addr = addr_q;

    always_comb begin
        rd_data = '0;
        rsp_q   = 1'b0;
        unique case (cmd.op)
            OP_RD_CMP:      begin rd_data = cmp_level;             rsp_q = 1'b1; end
            OP_RD_TRIP_RST: begin rd_data = trip_q;                rsp_q = 1'b1; end
            OP_RD_LOCK:     begin rd_data = chan_lock;             rsp_q = 1'b1; end
            OP_RD_ADDR:     begin rd_data = zext_addr(addr_q);     rsp_q = 1'b1; end
            OP_RD_TEST:     begin rd_data = test_out;              rsp_q = 1'b1; end
            OP_RD_THR:      begin rd_data = zext_thr(thr_q[cmd.chan]); rsp_q = 1'b1; end
            OP_RD_ID:       begin rd_data = {8'(ID_HI), SERIAL_NO}; rsp_q = 1'b1; end
            OP_WR_LOCK,
            OP_WR_ADDR,
            OP_CLEAR:       rsp_q = !glob_on;
            OP_WR_TEST:     rsp_q = !(|eff_lock);
            OP_WR_THR:      rsp_q = !eff_lock[cmd.chan];
            OP_GLOCK_OFF,
            OP_GLOCK_ON:    rsp_q = 1'b1;
            default:        rsp_q = 1'b0;
        endcase
    end

    AST_Q_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cmd_stb |-> (!rsp_q && rd_data == '0)); // R12

    AST_CLEAR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_CLEAR && glob_on) |=> $stable(port_addr)); // R10

endmodule

// File: tb/test_guarded_chan_regs.sv
`timescale 1ns/1ps
module test_guarded_chan_regs;

    localparam int STRETCH = 8;
    localparam logic [7:0] SER = 8'h5C;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [4:0]   cmd_fn = '0;
    logic [3:0]   cmd_sub = '0;
    logic         cmd_stb = 1'b0;
    logic [15:0]  wr_data = '0;
    logic [15:0]  cmp_level = '0;
    logic [15:0]  rd_data;
    logic         rsp_q;
    logic [15:0]  test_out;
    logic [191:0] thr_out;
    logic [4:0]   port_addr;
    logic         trip_led;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [15:0] got_rd;
    logic        got_q;

    always #2.5 clk = ~clk;

    guarded_chan_regs #(.SERIAL_NO(SER), .STRETCH_CYC(STRETCH)) i_guarded_chan_regs (
        .clk(clk), .rst(rst), .cmd_fn(cmd_fn), .cmd_sub(cmd_sub), .cmd_stb(cmd_stb),
        .wr_data(wr_data), .cmp_level(cmp_level), .rd_data(rd_data), .rsp_q(rsp_q),
        .test_out(test_out), .thr_out(thr_out), .port_addr(port_addr), .trip_led(trip_led)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Issue one strobed command; capture read data and Q during the strobe.
    task automatic do_cmd(input logic [4:0] fn, input logic [3:0] sub, input logic [15:0] d);
        @(negedge clk);
        cmd_fn = fn; cmd_sub = sub; wr_data = d; cmd_stb = 1'b1;
        #1;
        got_rd = rd_data;
        got_q  = rsp_q;
        @(negedge clk);
        cmd_stb = 1'b0; cmd_fn = '0; cmd_sub = '0; wr_data = '0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check("R12 idle rd", 32'(rd_data), 32'h0);
        check("R12 idle q", 32'(rsp_q), 32'h0);
        check("R7 addr after reset", 32'(port_addr), 32'h1F);
        check("R8 test after reset", 32'(test_out), 32'h0);
        check("R9 thr after reset", 32'(thr_out[191:160] | thr_out[31:0]), 32'h0);
        check("R4 led after reset", 32'(trip_led), 32'h0);
    endtask

    task automatic t_ident();
        do_cmd(5'd3, 4'd0, 16'h0);
        check("R11 id data", 32'(got_rd), 32'h425C);
        check("R11 id q", 32'(got_q), 32'h1);
        do_cmd(5'd7, 4'd3, 16'hFFFF);
        check("R12 undefined q", 32'(got_q), 32'h0);
        check("R12 undefined rd", 32'(got_rd), 32'h0);
    endtask

    task automatic t_trip();
        @(negedge clk); cmp_level = 16'h0008;
        @(negedge clk); cmp_level = 16'h0000;
        do_cmd(5'd0, 4'd0, 16'h0);
        check("R2 live read low", 32'(got_rd), 32'h0);
        check("R2 live read q", 32'(got_q), 32'h1);
        do_cmd(5'd2, 4'd0, 16'h0);
        check("R1 latched pulse", 32'(got_rd), 32'h0008);
        check("R3 read-reset q", 32'(got_q), 32'h1);
        do_cmd(5'd2, 4'd0, 16'h0);
        check("R3 cleared after read", 32'(got_rd), 32'h0);
        cmp_level = 16'h00A0;
        do_cmd(5'd0, 4'd0, 16'h0);
        check("R2 live read high", 32'(got_rd), 32'h00A0);
        do_cmd(5'd2, 4'd0, 16'h0);
        check("R3 first read held level", 32'(got_rd), 32'h00A0);
        do_cmd(5'd2, 4'd0, 16'h0);
        check("R3 re-set while level high", 32'(got_rd), 32'h00A0);
        cmp_level = 16'h0000;
        do_cmd(5'd2, 4'd0, 16'h0);
        check("R3 last latched value", 32'(got_rd), 32'h00A0);
        do_cmd(5'd2, 4'd0, 16'h0);
        check("R3 empty after level low", 32'(got_rd), 32'h0);
    endtask

    task automatic t_stretch();
        int n;
        @(negedge clk); cmp_level = 16'h0001;
        @(negedge clk); cmp_level = 16'h0000;
        repeat (20) @(negedge clk);
        check("R4 led while flag set", 32'(trip_led), 32'h1);
        do_cmd(5'd2, 4'd0, 16'h0);
        check("R1 flag held", 32'(got_rd), 32'h0001);
        n = 0;
        while (trip_led && n < 100) begin
            n++;
            @(negedge clk);
        end
        check("R4 stretch length", 32'(n), 32'(STRETCH));
    endtask

    task automatic t_glock();
        do_cmd(5'd17, 4'd12, 16'h0004);
        check("R6 lock write q", 32'(got_q), 32'h1);
        do_cmd(5'd1, 4'd12, 16'h0);
        check("R6 lock read", 32'(got_rd), 32'h0004);
        do_cmd(5'd17, 4'd11, 16'hFFF3);
        check("R7 addr write q", 32'(got_q), 32'h1);
        do_cmd(5'd1, 4'd11, 16'h0);
        check("R7 addr read", 32'(got_rd), 32'h0013);
        check("R7 addr port", 32'(port_addr), 32'h13);
        do_cmd(5'd21, 4'd2, 16'h0123);
        check("R9 thr write unlocked", 32'(got_q), 32'h1);
        do_cmd(5'd29, 4'd1, 16'h0);
        check("R5 global on q", 32'(got_q), 32'h1);
        do_cmd(5'd17, 4'd12, 16'hFFFF);
        check("R6 lock write refused", 32'(got_q), 32'h0);
        do_cmd(5'd1, 4'd12, 16'h0);
        check("R6 lock unchanged", 32'(got_rd), 32'h0004);
        do_cmd(5'd17, 4'd11, 16'h0005);
        check("R7 addr write refused", 32'(got_q), 32'h0);
        check("R7 addr unchanged", 32'(port_addr), 32'h13);
        do_cmd(5'd9, 4'd0, 16'h0);
        check("R10 clear refused", 32'(got_q), 32'h0);
        check("R10 addr kept", 32'(port_addr), 32'h13);
        do_cmd(5'd1, 4'd12, 16'h0);
        check("R10 lock kept", 32'(got_rd), 32'h0004);
    endtask

    task automatic t_test_thr();
        do_cmd(5'd18, 4'd14, 16'hFFFF);
        check("R8 test write warn q", 32'(got_q), 32'h0);
        check("R8 locked bit kept", 32'(test_out), 32'hFFFB);
        do_cmd(5'd2, 4'd14, 16'h0);
        check("R8 test read", 32'(got_rd), 32'hFFFB);
        check("R8 test read q", 32'(got_q), 32'h1);
        do_cmd(5'd21, 4'd2, 16'h0777);
        check("R9 thr write locked q", 32'(got_q), 32'h0);
        do_cmd(5'd5, 4'd2, 16'h0);
        check("R9 locked thr kept", 32'(got_rd), 32'h0123);
        do_cmd(5'd21, 4'd7, 16'hFABC);
        check("R9 thr write other q", 32'(got_q), 32'h1);
        do_cmd(5'd5, 4'd7, 16'h0);
        check("R9 thr read masked", 32'(got_rd), 32'h0ABC);
        check("R9 thr read q", 32'(got_q), 32'h1);
        check("R9 thr port slice", 32'(thr_out[7*12 +: 12]), 32'hABC);
        do_cmd(5'd29, 4'd0, 16'h0);
        check("R5 global off q", 32'(got_q), 32'h1);
        do_cmd(5'd21, 4'd2, 16'h0456);
        check("R5 lock inactive q", 32'(got_q), 32'h1);
        do_cmd(5'd5, 4'd2, 16'h0);
        check("R5 lock inactive thr", 32'(got_rd), 32'h0456);
        do_cmd(5'd18, 4'd14, 16'h0004);
        check("R8 test write q", 32'(got_q), 32'h1);
        check("R8 test all written", 32'(test_out), 32'h0004);
    endtask

    task automatic t_clear();
        cmp_level = 16'h0200;
        @(negedge clk);
        do_cmd(5'd9, 4'd0, 16'h0);
        check("R10 clear q", 32'(got_q), 32'h1);
        check("R10 addr to 31", 32'(port_addr), 32'h1F);
        check("R10 test zero", 32'(test_out), 32'h0);
        check("R10 thr7 zero", 32'(thr_out[7*12 +: 12]), 32'h0);
        check("R10 thr2 zero", 32'(thr_out[2*12 +: 12]), 32'h0);
        do_cmd(5'd1, 4'd12, 16'h0);
        check("R10 lock zero", 32'(got_rd), 32'h0);
        cmp_level = 16'h0000;
        do_cmd(5'd2, 4'd0, 16'h0);
        check("R10 flag from live level", 32'(got_rd), 32'h0200);
    endtask

    initial begin
        #(100000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_ident();
        t_trip();
        t_stretch();
        t_glock();
        t_test_thr();
        t_clear();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule